// File: doc/BRIEF.md
# Page Write Buffer and Timed Program Sequencer

This block sits between the serial command front end of a small serial non-volatile memory and its storage array. Once the front end has decoded a write command, it passes the start address and then each received data byte to the block. The block keeps these bytes in a one-page buffer. The upper address bits stay fixed for the whole frame. The lower bits step through the page and wrap at its end, so a host that sends more than one page of data overwrites the earliest bytes of the frame.

When chip select returns high, the front end reports the end of the frame. The block then checks three things: the frame ended on a byte boundary, the protection unit granted the write, and at least one byte was received. If all three hold, it starts a self-timed program cycle. The cycle keeps `busy` high for a fixed number of system clocks. During the cycle the block writes only the buffer entries that were actually filled, one per clock, through a simple array write port. In the last clock of the cycle it pulses `cycle_done`, which the enclosing design uses to clear its write enable latch. While `busy` is high, the block ignores every start address, data byte and frame end. Frames that do not qualify start no cycle and discard whatever was buffered.

Top module: `pgw_sequencer`

## Requirements
- R1: After synchronous reset, `busy`, `arr_we` and `cycle_done` are all 0.
- R2: Data byte k of a frame (k = 0, 1, ...) starting at address A is written to the address whose upper ADDR_W-log2(PAGE_BYTES) bits equal those of A and whose lower log2(PAGE_BYTES) bits equal (A + k) mod PAGE_BYTES.
- R3: If a frame carries more than PAGE_BYTES data bytes, the lower address bits wrap inside the page. The array then receives, for each page slot, the last byte sent to that slot.
- R4: A program cycle issues exactly one array write for each distinct page slot that received a byte, and leaves every other array address unwritten.
- R5: A frame end starts a program cycle only when `frame_aligned`=1, `write_permit`=1 and at least one data byte was received. Otherwise no cycle starts and the buffer is discarded, so data bytes that arrive later without a new start address are ignored.
- R6: `busy` rises in the clock after the qualifying frame end and stays high for exactly CYCLE_CLKS clocks.
- R7: `cycle_done` is a single-clock pulse, issued in the last clock in which `busy` is high, exactly once per program cycle.
- R8: While `busy` is 1, `start_valid`, `byte_valid` and `frame_end` have no effect. They neither change the data being programmed nor start a further cycle.
- R9: Within one program cycle, array writes occur in strictly ascending order of the lower (page slot) address bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | One-clock strobe: the write start address is present |
| start_addr | input | ADDR_W | Array address of the first data byte |
| byte_valid | input | 1 | One-clock strobe: a complete data byte is present |
| byte_data | input | 8 | Received data byte |
| frame_end | input | 1 | One-clock strobe: chip select has returned high |
| frame_aligned | input | 1 | Qualifies frame_end: the frame ended on a whole byte |
| write_permit | input | 1 | Qualifies frame_end: the protection unit allows the write |
| busy | output | 1 | A program cycle is in progress |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | 8 | Array write data |
| cycle_done | output | 1 | Program cycle completion pulse (clears the write enable latch) |

## Verification
A wrong slot pointer or a wrong upper-address latch puts bytes at the wrong array addresses. A full scan of the array model after each cycle exposes this within CYCLE_CLKS clocks of the frame end. Valid flags that fail to clear show up as extra array writes, or as a cycle that starts from stale data in the next frame. A counter off by one changes the measured length of `busy`, and a lost lock lets a frame sent during a cycle start a second cycle or alter the array contents. The bench sweeps every start slot against frame lengths below, at and above one page, so wrap faults cannot escape.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

    // Action taken when the front end reports the end of a frame
    typedef enum logic [1:0] {
        END_NONE    = 2'd0,
        END_COMMIT  = 2'd1,
        END_DISCARD = 2'd2
    } end_act_e;

    // One array write request from the sequencer
    typedef struct packed {
        logic       we;
        logic [7:0] data;
    } wr_slot_t;

    function automatic end_act_e classify_end(
        input logic ended,
        input logic aligned,
        input logic permit,
        input logic any_data
    );
        if (!ended)
            return END_NONE;
        if (aligned && permit && any_data)
            return END_COMMIT;
        return END_DISCARD;
    endfunction

endpackage

// File: rtl/pgw_page_buf.sv
module pgw_page_buf #(
    parameter int PAGE_BYTES = 32,
    parameter int ADDR_W     = 11,
    localparam int IDX_W     = $clog2(PAGE_BYTES),
    localparam int HI_W      = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lock,
    input  logic              flush,
    input  logic              start_valid,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output pgw_pkg::wr_slot_t rd_slot,
    output logic              any_vld,
    output logic [HI_W-1:0]   page_hi
);
    logic [7:0]            store [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] vld;
    logic [IDX_W-1:0]      ptr;
    logic [HI_W-1:0]       hi_q;
    logic                  armed;
    logic                  take_addr;
    logic                  take_byte;

    assign take_addr = !flush && !lock && start_valid;
    assign take_byte = !flush && !lock && !start_valid && byte_valid && armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld   <= '0;
            armed <= 1'b0;
            ptr   <= '0;
            hi_q  <= '0;
        end else if (flush) begin
            vld   <= '0;
            armed <= 1'b0;
        end else if (take_addr) begin
            hi_q  <= start_addr[ADDR_W-1:IDX_W];
            ptr   <= start_addr[IDX_W-1:0];
            vld   <= '0;
            armed <= 1'b1;
        end else if (take_byte) begin
            vld[ptr] <= 1'b1;
            ptr      <= ptr + 1'b1;   // wraps inside the page
        end
    end

    always_ff @(posedge clk) begin
        if (take_byte)
            store[ptr] <= byte_data;
    end

    assign rd_slot.we   = vld[rd_idx];
    assign rd_slot.data = store[rd_idx];
    assign any_vld      = |vld;
    assign page_hi      = hi_q;

    AST_BUF_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (lock && !flush) |=> ($stable(vld) && $stable(hi_q))) // R8
        else $error("buffer changed while locked");

endmodule

// File: rtl/pgw_prog_timer.sv
module pgw_prog_timer #(
    parameter int PAGE_BYTES = 32,
    parameter int CYCLE_CLKS = 64,
    localparam int IDX_W     = $clog2(PAGE_BYTES),
    localparam int CNT_W     = $clog2(CYCLE_CLKS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             launch,
    output logic             busy,
    output logic             slot_live,
    output logic [IDX_W-1:0] slot_idx,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (launch && !busy) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (busy) begin
            if (cnt == CNT_W'(CYCLE_CLKS - 1))
                busy <= 1'b0;
            else
                cnt <= cnt + 1'b1;
        end
    end

    assign done      = busy && (cnt == CNT_W'(CYCLE_CLKS - 1));
    assign slot_live = busy && (cnt < CNT_W'(PAGE_BYTES));
    assign slot_idx  = cnt[IDX_W-1:0];

    AST_LAUNCH_STARTS: assert property (@(posedge clk) disable iff (rst)
        (launch && !busy) |=> (busy && slot_live && slot_idx == '0)) // R6
        else $error("launch did not start a cycle");

    AST_DONE_ENDS: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy) // R7
        else $error("busy survived the done pulse");

    AST_DONE_ONCE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) // R7
        else $error("done longer than one clock");

endmodule

// File: rtl/pgw_sequencer.sv
module pgw_sequencer #(
    parameter int PAGE_BYTES = 32,
    parameter int ADDR_W     = 11,
    parameter int CYCLE_CLKS = 64,
    localparam int IDX_W     = $clog2(PAGE_BYTES),
    localparam int HI_W      = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_valid,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic              frame_end,
    input  logic              frame_aligned,
    input  logic              write_permit,
    output logic              busy,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [7:0]        arr_wdata,
    output logic              cycle_done
);
    import pgw_pkg::*;

    end_act_e          act;
    wr_slot_t          slot;
    logic              any_vld;
    logic [HI_W-1:0]   page_hi;
    logic [IDX_W-1:0]  slot_idx;
    logic              slot_live;
    logic              launch;
    logic              flush;

    assign act    = classify_end(frame_end, frame_aligned, write_permit, any_vld);
    assign launch = !busy && (act == END_COMMIT);
    assign flush  = (!busy && (act == END_DISCARD)) || cycle_done;

    pgw_page_buf #(
        .PAGE_BYTES (PAGE_BYTES),
        .ADDR_W     (ADDR_W)
    ) u_buf (
        .clk         (clk),
        .rst         (rst),
        .lock        (busy),
        .flush       (flush),
        .start_valid (start_valid),
        .start_addr  (start_addr),
        .byte_valid  (byte_valid),
        .byte_data   (byte_data),
        .rd_idx      (slot_idx),
        .rd_slot     (slot),
        .any_vld     (any_vld),
        .page_hi     (page_hi)
    );

    pgw_prog_timer #(
        .PAGE_BYTES (PAGE_BYTES),
        .CYCLE_CLKS (CYCLE_CLKS)
    ) u_tmr (
        .clk       (clk),
        .rst       (rst),
        .launch    (launch),
        .busy      (busy),
        .slot_live (slot_live),
        .slot_idx  (slot_idx),
        .done      (cycle_done)
    );

    assign arr_we    = slot_live && slot.we;
    assign arr_addr  = {page_hi, slot_idx};
    assign arr_wdata = slot.data;

    AST_WE_IN_CYCLE: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> busy) // R4
        else $error("array write outside a program cycle");

    AST_DENIED_IDLE: assert property (@(posedge clk) disable iff (rst)
        (frame_end && !busy && !(frame_aligned && write_permit)) |=> !busy) // R5
        else $error("unqualified frame started a cycle");

    AST_PAGE_HELD: assert property (@(posedge clk) disable iff (rst)
        (arr_we && $past(arr_we)) |-> $stable(arr_addr[ADDR_W-1:IDX_W])) // R2
        else $error("upper address moved during a cycle");

endmodule

// File: tb/test_pgw_sequencer.sv
module test_pgw_sequencer;
    localparam int P   = 16;
    localparam int AW  = 8;
    localparam int CYC = 24;
    localparam int NA  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic          start_valid, byte_valid, frame_end, frame_aligned, write_permit;
    logic [AW-1:0] start_addr;
    logic [7:0]    byte_data;
    logic          busy, arr_we, cycle_done;
    logic [AW-1:0] arr_addr;
    logic [7:0]    arr_wdata;

    int errors = 0;
    int checks = 0;

    logic [7:0] act_mem [NA];
    logic [7:0] exp_mem [NA];
    int         wr_cnt;
    int         order_bad;
    logic       have_prev;
    logic [3:0] last_low;

    always #10 clk = ~clk;

    pgw_sequencer #(.PAGE_BYTES(P), .ADDR_W(AW), .CYCLE_CLKS(CYC)) i_pgw_sequencer (
        .clk(clk), .rst(rst),
        .start_valid(start_valid), .start_addr(start_addr),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .frame_end(frame_end), .frame_aligned(frame_aligned), .write_permit(write_permit),
        .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
        .cycle_done(cycle_done)
    );

    // Array model fed by the write port
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NA; i++) act_mem[i] <= 8'h00;
            wr_cnt    <= 0;
            order_bad <= 0;
            have_prev <= 1'b0;
            last_low  <= '0;
        end else begin
            if (arr_we) begin
                act_mem[arr_addr] <= arr_wdata;
                wr_cnt            <= wr_cnt + 1;
                if (have_prev && arr_addr[3:0] <= last_low) order_bad <= order_bad + 1;
                have_prev <= 1'b1;
                last_low  <= arr_addr[3:0];
            end
            if (cycle_done) have_prev <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int k);
        return 8'((seed * 7 + k * 13 + 5) & 8'hFF);
    endfunction

    task automatic idle_inputs();
        start_valid = 0; byte_valid = 0; frame_end = 0;
        frame_aligned = 0; write_permit = 0; start_addr = '0; byte_data = '0;
    endtask

    task automatic drive_frame(input int addr, input int n, input int seed,
                               input bit aligned, input bit permit);
        start_valid = 1; start_addr = AW'(addr);
        @(negedge clk);
        start_valid = 0;
        for (int k = 0; k < n; k++) begin
            byte_valid = 1; byte_data = pat(seed, k);
            @(negedge clk);
        end
        byte_valid = 0;
        frame_end = 1; frame_aligned = aligned; write_permit = permit;
        @(negedge clk);
        frame_end = 0; frame_aligned = 0; write_permit = 0;
    endtask

    // Counts busy clocks and done pulses from the current negedge on
    task automatic measure(output int bcycles, output int dones);
        bcycles = 0; dones = 0;
        while (busy && bcycles < 4 * CYC) begin
            if (cycle_done) dones++;
            bcycles++;
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic compare_mem(input string req);
        int bad = 0;
        for (int i = 0; i < NA; i++) if (act_mem[i] !== exp_mem[i]) bad++;
        chk(bad == 0, req, bad, 0);
    endtask

    task automatic full_frame(input int addr, input int n, input int seed,
                              input bit aligned, input bit permit);
        int  w0, bc, dn, expw, ob0;
        bit  commit;
        w0  = wr_cnt;
        ob0 = order_bad;
        commit = aligned && permit && (n > 0);
        drive_frame(addr, n, seed, aligned, permit);
        measure(bc, dn);
        if (commit)
            for (int k = 0; k < n; k++)
                exp_mem[(addr & ~(P - 1)) | ((addr + k) & (P - 1))] = pat(seed, k);
        expw = commit ? ((n < P) ? n : P) : 0;
        chk(bc == (commit ? CYC : 0), "R6 busy length", bc, commit ? CYC : 0);
        chk(dn == (commit ? 1 : 0), "R7 done pulses", dn, commit ? 1 : 0);
        chk(wr_cnt - w0 == expw, "R4 write count", wr_cnt - w0, expw);
        chk(order_bad == ob0, "R9 write order", order_bad - ob0, 0);
        if (!commit)      compare_mem("R5 no program");
        else if (n > P)   compare_mem("R3 page wrap");
        else              compare_mem("R2 placement");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int bc, dn, w0;
        int lens [9] = '{1, 2, 5, 15, 16, 17, 20, 31, 33};
        for (int i = 0; i < NA; i++) exp_mem[i] = 8'h00;
        idle_inputs();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(busy == 0 && arr_we == 0 && cycle_done == 0, "R1 reset state",
            {busy, arr_we, cycle_done}, 0);

        // Sweep every start slot against several frame lengths
        for (int lo = 0; lo < P; lo++)
            for (int j = 0; j < 9; j++)
                full_frame(((lo * 5 + lens[j]) % P) * P + lo, lens[j], lo * 31 + j, 1, 1);

        // Unqualified frame ends
        full_frame(8'h35, 4, 901, 0, 1);   // partial byte
        full_frame(8'h47, 4, 902, 1, 0);   // not permitted
        full_frame(8'h58, 0, 903, 1, 1);   // no data bytes

        // Discarded buffer: bytes without a new address are ignored
        drive_frame(8'h60, 3, 904, 0, 1);
        for (int k = 0; k < 3; k++) begin
            byte_valid = 1; byte_data = 8'hA5; @(negedge clk);
        end
        byte_valid = 0;
        frame_end = 1; frame_aligned = 1; write_permit = 1;
        @(negedge clk);
        frame_end = 0; frame_aligned = 0; write_permit = 0;
        chk(busy == 0, "R5 stale bytes dropped", busy, 0);
        repeat (2) @(negedge clk);
        compare_mem("R5 stale bytes dropped");

        // Inputs during a program cycle are ignored
        w0 = wr_cnt;
        drive_frame(8'h93, 5, 905, 1, 1);
        for (int k = 0; k < 5; k++) exp_mem[8'h90 | ((3 + k) & (P - 1))] = pat(905, k);
        start_valid = 1; start_addr = 8'hC0; @(negedge clk);
        start_valid = 0;
        for (int k = 0; k < 4; k++) begin
            byte_valid = 1; byte_data = 8'h3C; @(negedge clk);
        end
        byte_valid = 0;
        frame_end = 1; frame_aligned = 1; write_permit = 1; @(negedge clk);
        frame_end = 0; frame_aligned = 0; write_permit = 0;
        measure(bc, dn);
        chk(bc == CYC - 6, "R8 cycle unaffected", bc, CYC - 6);
        repeat (4) begin
            chk(busy == 0, "R8 no relaunch", busy, 0);
            @(negedge clk);
        end
        chk(wr_cnt - w0 == 5, "R8 write count", wr_cnt - w0, 5);
        compare_mem("R8 contents");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule